// File: doc/BRIEF.md
# Converter Update-Rate and Settling Sequencer

This block is the digital timing core of a sigma-delta converter. A clock-select bit and a two-bit filter-select field together pick one of eight output update rates. The block divides the master clock down to an update tick at the chosen rate. A synchronisation-hold input freezes the filter timing. After the hold is released, the block counts out the filter settling time and then publishes results.

Upstream filter logic presents each new 16-bit result with a one-cycle strobe. The block keeps the most recent strobed value pending. On an update tick, once settling is complete, it copies that value to the result output and pulls the active-low ready flag down. The flag returns high when the host signals that a read has completed, or on the following tick if no read occurs. Holding synchronisation stops ticks and discards any pending result, but it never raises a ready flag that is already low.

Top module: `conv_rate_sequencer`

## Requirements
- R1: With `clk_sel_i`=0 the setting index is {clk_sel_i, filt_sel_i[1], filt_sel_i[0]}. Indices 0, 1, 2 and 3 give tick periods of MCLK_HZ/20, MCLK_HZ/25, MCLK_HZ/100 and MCLK_HZ/200 master-clock cycles (1500, 1200, 300 and 150 with the default MCLK_HZ of 30000).
- R2: With `clk_sel_i`=1, indices 4, 5, 6 and 7 give tick periods of MCLK_HZ/50, MCLK_HZ/60, MCLK_HZ/250 and MCLK_HZ/500 cycles (600, 500, 120 and 60 by default).
- R3: While `sync_hold_i` is 1, `tick_o` stays 0, the settling count restarts, and any pending result (including one strobed during the hold) is discarded, so it is never published.
- R4: After `sync_hold_i` is released, the first and second ticks never publish a result. The third tick is the first that can publish.
- R5: `sync_hold_i` never raises `drdy_n_o`. A low flag stays low throughout a hold unless a read completes.
- R6: A tick that occurs after settling, with a result pending, sets `drdy_n_o` to 0 in the next cycle. In that same cycle `res_data_o` shows the most recently strobed result.
- R7: A one-cycle `rd_done_i` pulse sets `drdy_n_o` to 1 in the next cycle, unless a result is published in that same cycle.
- R8: Without a read, `drdy_n_o` returns to 1 after the next tick that publishes nothing.
- R9: A change of the setting reloads the divider. The first tick after the change is seen exactly one full period (of the new setting) later.
- R10: A synchronous reset drives `drdy_n_o` to 1, `res_data_o` to 0 and `tick_o` to 0, and restarts the three-tick settling sequence.
- R11: `res_valid_i` alone changes no output. A result reaches `res_data_o` only on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous reset, active high |
| clk_sel_i | input | 1 | Clock-select bit, most significant bit of the setting index |
| filt_sel_i | input | 2 | Filter-select field, lower two bits of the setting index |
| sync_hold_i | input | 1 | Filter synchronisation hold, active high |
| res_data_i | input | 16 | Result word from the filter |
| res_valid_i | input | 1 | One-cycle strobe that marks `res_data_i` as a new result |
| rd_done_i | input | 1 | One-cycle pulse: the host has finished reading the result |
| tick_o | output | 1 | One-cycle update tick |
| res_data_o | output | 16 | Last published result |
| drdy_n_o | output | 1 | Data-ready flag, active low |

## Verification
On every cycle, the assertions check the following:
- the divider count stays below the selected period, and the divider reloads on each setting change;
- a hold clears the settling count and the pending flag;
- a tick during settling leaves the output word untouched;
- a publishing tick lowers the flag with the right data;
- a read, or an empty tick, raises the flag;
- a hold never lifts a low flag.

Only the bench scenarios can show the rest:
- the actual tick periods for all eight settings;
- that a result strobed inside a hold never appears;
- that a result strobed just after release appears on the third tick and not before;
- that reset restarts this sequence.

// File: rtl/rss_pkg.sv
package rss_pkg;

    localparam int unsigned N_SET = 8;
    localparam int unsigned DFLT_MCLK_HZ = 30000;

    typedef int unsigned rate_tab_t [N_SET];

    // index = {clock select, filter select[1:0]}
    localparam rate_tab_t DFLT_RATES = '{20, 25, 100, 200, 50, 60, 250, 500};

    function automatic int unsigned slowest_rate(input rate_tab_t tab);
        int unsigned m;
        m = tab[0];
        for (int i = 1; i < N_SET; i++) begin
            if (tab[i] < m) m = tab[i];
        end
        return m;
    endfunction

endpackage

// File: rtl/rss_rate_sel.sv
module rss_rate_sel
    import rss_pkg::*;
#(
    parameter int unsigned MCLK_HZ = DFLT_MCLK_HZ,
    parameter rate_tab_t   RATE_HZ = DFLT_RATES,
    parameter int unsigned DIV_W   = 11
) (
    input  logic [2:0]       sel_i,
    output logic [DIV_W-1:0] div_o
);

    logic [DIV_W-1:0] div_tab [N_SET];

    for (genvar g = 0; g < N_SET; g++) begin : g_div
        localparam int unsigned RAW = MCLK_HZ / RATE_HZ[g];
        localparam int unsigned DV  = (RAW < 2) ? 2 : RAW;
        assign div_tab[g] = DIV_W'(DV);
    end

    assign div_o = div_tab[sel_i];

    always_comb begin
        assert_div_min_R1: assert (div_o >= DIV_W'(2));
    end

endmodule

// File: rtl/rss_tick_div.sv
module rss_tick_div #(
    parameter int unsigned DIV_W = 11
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             hold_i,
    input  logic [2:0]       sel_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [2:0]       sel;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    chg;

    always_comb begin
        st_d   = st_q;
        tick_o = 1'b0;
        chg    = (sel_i != st_q.sel);
        st_d.sel = sel_i;
        if (hold_i || chg) begin
            st_d.cnt = div_i - DIV_W'(1);
        end else if (st_q.cnt == '0) begin
            tick_o   = 1'b1;
            st_d.cnt = div_i - DIV_W'(1);
        end else begin
            st_d.cnt = st_q.cnt - DIV_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '{cnt: div_i - DIV_W'(1), sel: sel_i};
        end else begin
            st_q <= st_d;
        end
    end

    assert_cnt_in_range_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i == st_q.sel) |-> (st_q.cnt < div_i));

    assert_reload_on_change_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i != st_q.sel) |=> (st_q.cnt == $past(div_i) - DIV_W'(1)));

endmodule

// File: rtl/rss_settle.sv
module rss_settle #(
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned SETTLE_TICKS = 3
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              hold_i,
    input  logic              tick_i,
    input  logic [DATA_W-1:0] res_data_i,
    input  logic              res_valid_i,
    input  logic              rd_done_i,
    output logic [DATA_W-1:0] res_data_o,
    output logic              drdy_n_o
);

    localparam int unsigned SC_W = $clog2(SETTLE_TICKS + 1);
    localparam logic [SC_W-1:0] SC_LAST = SC_W'(SETTLE_TICKS - 1);

    typedef struct packed {
        logic [SC_W-1:0]   settle_cnt;
        logic              pend;
        logic [DATA_W-1:0] pend_data;
        logic [DATA_W-1:0] out_data;
        logic              drdy_n;
    } set_st_t;

    set_st_t st_d, st_q;
    logic    settled;
    logic    publish;

    always_comb begin
        st_d    = st_q;
        settled = (st_q.settle_cnt == SC_LAST);
        publish = tick_i && !hold_i && settled && st_q.pend;
        if (hold_i) begin
            st_d.settle_cnt = '0;
            st_d.pend       = 1'b0;
        end else begin
            if (tick_i) begin
                if (!settled) st_d.settle_cnt = st_q.settle_cnt + SC_W'(1);
                if (publish) begin
                    st_d.out_data = st_q.pend_data;
                    st_d.pend     = 1'b0;
                    st_d.drdy_n   = 1'b0;
                end else begin
                    st_d.drdy_n   = 1'b1;
                end
            end
            if (res_valid_i) begin
                st_d.pend      = 1'b1;
                st_d.pend_data = res_data_i;
            end
        end
        if (rd_done_i && !publish) st_d.drdy_n = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '{settle_cnt: '0, pend: 1'b0, pend_data: '0, out_data: '0, drdy_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign res_data_o = st_q.out_data;
    assign drdy_n_o   = st_q.drdy_n;

    assert_hold_clears_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        hold_i |=> (st_q.settle_cnt == '0 && !st_q.pend));

    assert_early_tick_quiet_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_i && st_q.settle_cnt != SC_LAST) |=> $stable(res_data_o));

    assert_hold_keeps_low_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (hold_i && !drdy_n_o && !rd_done_i) |=> !drdy_n_o);

    assert_publish_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_i && !hold_i && st_q.settle_cnt == SC_LAST && st_q.pend)
        |=> (!drdy_n_o && res_data_o == $past(st_q.pend_data)));

    assert_read_raises_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_done_i && !tick_i) |=> drdy_n_o);

    assert_empty_tick_raises_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_i && !hold_i && !st_q.pend) |=> drdy_n_o);

    assert_reset_state_R10: assert property (@(posedge clk_i)
        rst_i |=> (drdy_n_o && st_q.settle_cnt == '0 && res_data_o == '0));

endmodule

// File: rtl/conv_rate_sequencer.sv
module conv_rate_sequencer
    import rss_pkg::*;
#(
    parameter int unsigned MCLK_HZ      = DFLT_MCLK_HZ,
    parameter rate_tab_t   RATE_HZ      = DFLT_RATES,
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned SETTLE_TICKS = 3
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              clk_sel_i,
    input  logic [1:0]        filt_sel_i,
    input  logic              sync_hold_i,
    input  logic [DATA_W-1:0] res_data_i,
    input  logic              res_valid_i,
    input  logic              rd_done_i,
    output logic              tick_o,
    output logic [DATA_W-1:0] res_data_o,
    output logic              drdy_n_o
);

    localparam int unsigned MAX_DIV = MCLK_HZ / slowest_rate(RATE_HZ);
    localparam int unsigned DIV_W   = $clog2(MAX_DIV + 1);

    logic [2:0]       sel;
    logic [DIV_W-1:0] div;

    assign sel = {clk_sel_i, filt_sel_i};

    rss_rate_sel #(.MCLK_HZ(MCLK_HZ), .RATE_HZ(RATE_HZ), .DIV_W(DIV_W)) rate_sel_i (
        .sel_i (sel),
        .div_o (div)
    );

    rss_tick_div #(.DIV_W(DIV_W)) tick_div_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .hold_i (sync_hold_i),
        .sel_i  (sel),
        .div_i  (div),
        .tick_o (tick_o)
    );

    rss_settle #(.DATA_W(DATA_W), .SETTLE_TICKS(SETTLE_TICKS)) settle_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .hold_i      (sync_hold_i),
        .tick_i      (tick_o),
        .res_data_i  (res_data_i),
        .res_valid_i (res_valid_i),
        .rd_done_i   (rd_done_i),
        .res_data_o  (res_data_o),
        .drdy_n_o    (drdy_n_o)
    );

endmodule

// File: tb/conv_rate_sequencer_tb.sv
module conv_rate_sequencer_tb_top;

    localparam int unsigned MCLK = 30000;
    localparam int unsigned NV = 8;
    localparam logic [2:0]  VEC_SEL [NV] = '{3'd7, 3'd0, 3'd3, 3'd4, 3'd1, 3'd6, 3'd2, 3'd5};
    localparam int unsigned VEC_HZ  [NV] = '{500, 20, 200, 50, 25, 250, 100, 60};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_sel = 1'b0;
    logic [1:0]  filt_sel = 2'b00;
    logic        hold = 1'b0;
    logic [15:0] rdata = '0;
    logic        rvalid = 1'b0;
    logic        rd_done = 1'b0;
    logic        tick;
    logic [15:0] dout;
    logic        drdy_n;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    conv_rate_sequencer dut_i (
        .clk_i(clk), .rst_i(rst), .clk_sel_i(clk_sel), .filt_sel_i(filt_sel),
        .sync_hold_i(hold), .res_data_i(rdata), .res_valid_i(rvalid),
        .rd_done_i(rd_done), .tick_o(tick), .res_data_o(dout), .drdy_n_o(drdy_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick && n < 20000);
    endtask

    task automatic strobe(input logic [15:0] v);
        rdata = v; rvalid = 1'b1;
        @(negedge clk);
        rvalid = 1'b0;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int n;
        int seen;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk("R10 drdy after reset", int'(drdy_n), 1);
        chk("R10 data after reset", int'(dout), 0);
        chk("R10 tick after reset", int'(tick), 0);

        // rate vector table: R9 first tick after change, R1/R2 steady period
        for (int i = 0; i < NV; i++) begin
            {clk_sel, filt_sel} = VEC_SEL[i];
            wait_tick(n);
            chk("R9 first tick after setting change", n, int'(MCLK / VEC_HZ[i]));
            wait_tick(n);
            chk(VEC_SEL[i][2] ? "R2 tick period" : "R1 tick period", n, int'(MCLK / VEC_HZ[i]));
        end

        // R3: hold stops ticks, result strobed during hold is discarded
        {clk_sel, filt_sel} = 3'd7;
        @(negedge clk);
        hold = 1'b1;
        @(negedge clk);
        strobe(16'hDEAD);
        seen = 0;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (tick) seen++;
        end
        chk("R3 no ticks during hold", seen, 0);
        hold = 1'b0;
        for (int t = 0; t < 3; t++) begin
            wait_tick(n);
            @(negedge clk);
        end
        chk("R3 held result discarded drdy", int'(drdy_n), 1);
        chk("R3 held result discarded data", int'(dout), 0);

        // R11 strobe alone, R6 publish
        strobe(16'h1234);
        chk("R11 strobe does not reach output", int'(dout), 0);
        wait_tick(n);
        @(negedge clk);
        chk("R6 drdy low on publish", int'(drdy_n), 0);
        chk("R6 published data", int'(dout), 16'h1234);

        // R8 no read: next empty tick raises flag
        wait_tick(n);
        @(negedge clk);
        chk("R8 drdy high after empty tick", int'(drdy_n), 1);
        chk("R8 data kept", int'(dout), 16'h1234);

        // R7 read raises flag
        strobe(16'h5678);
        wait_tick(n);
        @(negedge clk);
        chk("R6 second publish", int'(dout), 16'h5678);
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
        chk("R7 drdy high after read", int'(drdy_n), 1);

        // R5 hold keeps low flag; R4 settling after release
        strobe(16'h9ABC);
        wait_tick(n);
        @(negedge clk);
        chk("R6 third publish drdy", int'(drdy_n), 0);
        hold = 1'b1;
        repeat (150) @(negedge clk);
        chk("R5 hold leaves drdy low", int'(drdy_n), 0);
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
        chk("R7 read during hold raises drdy", int'(drdy_n), 1);
        hold = 1'b0;
        strobe(16'h4242);
        for (int t = 1; t <= 2; t++) begin
            wait_tick(n);
            @(negedge clk);
            chk("R4 early tick keeps data", int'(dout), 16'h9ABC);
            chk("R4 early tick keeps drdy high", int'(drdy_n), 1);
        end
        wait_tick(n);
        @(negedge clk);
        chk("R4 third tick publishes data", int'(dout), 16'h4242);
        chk("R4 third tick drops drdy", int'(drdy_n), 0);

        // R10 reset mid-run restarts settling
        rst = 1'b1;
        @(negedge clk);
        chk("R10 reset raises drdy", int'(drdy_n), 1);
        chk("R10 reset clears data", int'(dout), 0);
        chk("R10 reset clears tick", int'(tick), 0);
        @(negedge clk);
        rst = 1'b0;
        strobe(16'h7777);
        for (int t = 1; t <= 2; t++) begin
            wait_tick(n);
            @(negedge clk);
            chk("R10 settling restarted no publish", int'(dout), 0);
        end
        wait_tick(n);
        @(negedge clk);
        chk("R10 publish on third tick after reset", int'(dout), 16'h7777);
        chk("R10 drdy low on third tick after reset", int'(drdy_n), 0);

        finish_run();
    end

endmodule